// File: doc/BRIEF.md
# Pixel Reconstruction Unit

This unit rebuilds decoded pixels for one 8x8 block at a time. It takes the output of an inverse transform (a residual stream) and, when needed, a motion-compensated prediction stream. It returns final 8-bit pixels. Each input stream and the output stream carry one pixel per cycle and use a valid/ready handshake. The unit does not fetch the prediction and does not run the transform.

Two flags arrive with the residual word and set how a block is treated. The first flag selects intra or inter. An intra block carries finished 8-bit pixels, which are passed straight to the output, and the prediction stream is left untouched. An inter block carries signed residuals. Each residual is added to the matching prediction pixel, and the sum is saturated to the pixel range. The second flag selects how residuals are coded: full signed 16-bit words, or a compact signed 8-bit form in the low byte that is sign-extended before the add. Both flags take effect on the first pixel of a block and stay in force for all of its pixels.

Top module: `pix_recon`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low, and the next accepted pixel counts as pixel 0 of a block.
- R2: In an intra block, each output pixel equals `res_data[7:0]` of the matching residual word, read as unsigned.
- R3: In an inter block with the 16-bit format (`res_packed`=0), each output pixel is `pred_data` plus `res_data` read as a signed 16-bit value, when that sum lies in 0..255.
- R4: An inter sum below 0 gives an output of 0.
- R5: An inter sum above 255 gives an output of 255.
- R6: With `res_packed`=1, the residual is `res_data[7:0]` read as signed 8-bit and sign-extended, and `res_data[15:8]` has no effect.
- R7: `res_intra` and `res_packed` are sampled on the first pixel of each block (pixels are counted from 0 to 63), and changes to them on pixels 1..63 have no effect.
- R8: In an intra block, `pred_ready` stays low, and pixels are accepted whatever the state of `pred_valid` or `pred_data`.
- R9: In an inter block, a residual is accepted only in the same cycle as a prediction pixel. `pred_ready` is high only while `res_valid` is high, and `res_ready` is low while `pred_valid` is low.
- R10: `out_last` is high on the 64th output pixel of each block and low on the others.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R12: When the output is free or being drained, one pixel per cycle is accepted, and its result appears on the output one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | Residual word is present |
| res_ready | output | 1 | Residual word is taken this cycle |
| res_data | input | 16 | Residual, or the intra pixel in bits 7:0 |
| res_intra | input | 1 | Block is intra (sampled on the first pixel) |
| res_packed | input | 1 | Residual uses the compact signed 8-bit form (sampled on the first pixel) |
| pred_valid | input | 1 | Prediction pixel is present |
| pred_ready | output | 1 | Prediction pixel is taken this cycle |
| pred_data | input | 8 | Prediction pixel, unsigned |
| out_valid | output | 1 | Reconstructed pixel is present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 8 | Reconstructed pixel |
| out_last | output | 1 | Marks the final pixel of a block |

## Verification
Each accepted input pixel produces a registered result that is due on the output exactly one cycle after the accepting edge. After that, the result stays on the output for as long as `out_ready` is low. The bench drives inputs on the falling edge and reads the handshake shortly afterwards. It pushes the expected pixel into an ordered queue only when `res_valid` and `res_ready` are both high before the rising edge. The output side is compared in the middle of a later low phase, and only when `out_valid` and `out_ready` are both high. This keeps every comparison tied to an actual transfer rather than a counted delay. The handshake rules (R8 and R9) are read from the ready outputs in the same half-cycle as the input values that produce them.

// File: rtl/recon_pkg.sv
// Package recon_pkg
// Shared widths and the per-block mode record for the pixel reconstruction
// unit. Assumes one pixel per handshake and square blocks.
package recon_pkg;
    localparam int unsigned PIX_W_D   = 8;   // pixel width
    localparam int unsigned RES_W_D   = 16;  // full residual width
    localparam int unsigned PACK_W_D  = 8;   // compact residual width
    localparam int unsigned BLK_PIX_D = 64;  // pixels per block

    // Per-block mode record, sampled on the first pixel
    typedef struct packed {
        logic intra;   // 1: overwrite with incoming pixel
        logic packed8; // 1: residual is compact signed form
    } blk_mode_t;
endpackage

// File: rtl/recon_blk_ctrl.sv
// Module recon_blk_ctrl
// Counts accepted pixels within a block and holds the block mode.
// On pixel 0 the live flags are used directly and captured.
// On the other pixels the captured copy is used.
// Assumes fire is high only when a pixel is actually accepted.
module recon_blk_ctrl
    import recon_pkg::*;
#(
    parameter int unsigned BLK_PIX = BLK_PIX_D
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  blk_mode_t mode_in,
    output blk_mode_t mode_eff,
    output logic      last_pix
);
    localparam int unsigned CNT_W = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_PIX - 1);

    logic [CNT_W-1:0] pix_cnt;
    blk_mode_t        mode_hold;
    logic             first_pix;

    // Decode the position in the block and choose the mode source
    always_comb begin
        first_pix = (pix_cnt == '0);
        last_pix  = (pix_cnt == LAST_IDX);
        mode_eff  = first_pix ? mode_in : mode_hold;
    end

    // Advance the pixel index and wrap it at the end of the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (fire) begin
            pix_cnt <= last_pix ? '0 : pix_cnt + 1'b1;
        end
    end

    // Capture the mode flags on the first pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_hold <= '0;
        end else if (fire && first_pix) begin
            mode_hold <= mode_in;
        end
    end
endmodule

// File: rtl/recon_res_unpack.sv
// Module recon_res_unpack
// Turns a raw residual word into a signed full-width residual.
// In compact form the low PACK_W bits are sign-extended and the upper bits
// are ignored. Assumes PACK_W <= RES_W.
module recon_res_unpack #(
    parameter int unsigned RES_W  = 16,
    parameter int unsigned PACK_W = 8
) (
    input  logic [RES_W-1:0]        raw,
    input  logic                    packed8,
    output logic signed [RES_W-1:0] res
);
    logic signed [RES_W-1:0] res_compact;

    generate
        if (PACK_W < RES_W) begin : g_ext
            // Sign-extend the compact residual
            always_comb res_compact = {{(RES_W-PACK_W){raw[PACK_W-1]}}, raw[PACK_W-1:0]};
        end else begin : g_same
            // Compact and full forms share a width
            always_comb res_compact = raw;
        end
    endgenerate

    // Pick the residual form for this block
    always_comb res = packed8 ? res_compact : $signed(raw);
endmodule

// File: rtl/recon_add_clip.sv
// Module recon_add_clip
// Forms one reconstructed pixel. Intra passes the low pixel bits of the
// residual word through. Inter adds the signed residual to the unsigned
// prediction and saturates the sum to 0..2^PIX_W-1.
// Assumes RES_W > PIX_W.
module recon_add_clip #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned RES_W = 16
) (
    input  logic                    intra,
    input  logic [PIX_W-1:0]        intra_pix,
    input  logic [PIX_W-1:0]        pred,
    input  logic signed [RES_W-1:0] res,
    output logic [PIX_W-1:0]        pix
);
    localparam int unsigned SUM_W = RES_W + 2;
    localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] sum;
    logic [PIX_W-1:0]        clipped;

    // Widen both operands and add them without overflow
    always_comb sum = $signed({{(SUM_W-PIX_W){1'b0}}, pred}) + SUM_W'(res);

    // Saturate the sum to the pixel range
    always_comb begin
        if (sum < 0)
            clipped = '0;
        else if (sum > PIX_MAX)
            clipped = '1;
        else
            clipped = sum[PIX_W-1:0];
    end

    // Intra overwrites, inter uses the clipped sum
    always_comb pix = intra ? intra_pix : clipped;
endmodule

// File: rtl/recon_out_stage.sv
// Module recon_out_stage
// A single output register with a valid/ready handshake. It can be loaded
// when it is empty or being drained, and it holds while stalled.
module recon_out_stage #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_W-1:0] load_pix,
    input  logic             load_last,
    input  logic             out_ready,
    output logic             can_load,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_last
);
    // The slot is free when it is empty or its content leaves this cycle
    always_comb can_load = !out_valid || out_ready;

    // Track whether the register holds a pixel
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (can_load)
            out_valid <= load;
    end

    // Capture pixel and end marker on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_last <= 1'b0;
        end else if (can_load && load) begin
            out_data <= load_pix;
            out_last <= load_last;
        end else if (can_load) begin
            out_last <= 1'b0;
        end
    end
endmodule

// File: rtl/pix_recon.sv
// Module pix_recon
// Pixel reconstruction top. It joins the residual stream and, for inter
// blocks, the prediction stream into one registered output stream.
// Assumes block boundaries are defined only by the pixel count.
module pix_recon
    import recon_pkg::*;
#(
    parameter int unsigned PIX_W   = PIX_W_D,
    parameter int unsigned RES_W   = RES_W_D,
    parameter int unsigned PACK_W  = PACK_W_D,
    parameter int unsigned BLK_PIX = BLK_PIX_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    output logic             res_ready,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_intra,
    input  logic             res_packed,
    input  logic             pred_valid,
    output logic             pred_ready,
    input  logic [PIX_W-1:0] pred_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_last
);
    blk_mode_t               mode_in, mode_eff;
    logic                    last_pix, can_load, fire, need_pred;
    logic signed [RES_W-1:0] res_s;
    logic [PIX_W-1:0]        pix;

    // Gather the live mode flags
    always_comb begin
        mode_in.intra   = res_intra;
        mode_in.packed8 = res_packed;
    end

    // Handshake: inter needs both streams, intra needs only the residual
    always_comb begin
        need_pred  = !mode_eff.intra;
        res_ready  = can_load && (!need_pred || pred_valid);
        pred_ready = can_load && need_pred && res_valid;
        fire       = res_valid && res_ready;
    end

    recon_blk_ctrl #(.BLK_PIX(BLK_PIX)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .mode_in  (mode_in),
        .mode_eff (mode_eff),
        .last_pix (last_pix)
    );

    recon_res_unpack #(.RES_W(RES_W), .PACK_W(PACK_W)) u_unpack (
        .raw     (res_data),
        .packed8 (mode_eff.packed8),
        .res     (res_s)
    );

    recon_add_clip #(.PIX_W(PIX_W), .RES_W(RES_W)) u_add (
        .intra     (mode_eff.intra),
        .intra_pix (res_data[PIX_W-1:0]),
        .pred      (pred_data),
        .res       (res_s),
        .pix       (pix)
    );

    recon_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire),
        .load_pix  (pix),
        .load_last (last_pix),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );
endmodule

// File: rtl/recon_checks.sv
// Module recon_checks
// Protocol checks for pix_recon, attached with bind. It counts output
// transfers on its own to check where the block ends.
module recon_checks #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned BLK_PIX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic             res_ready,
    input logic             pred_valid,
    input logic             pred_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_last
);
    localparam int unsigned CW = $clog2(BLK_PIX) + 1;
    logic [CW-1:0] ocnt;

    // Count output transfers within a block
    always_ff @(posedge clk) begin
        if (!rst_n)
            ocnt <= '0;
        else if (out_valid && out_ready)
            ocnt <= (ocnt == CW'(BLK_PIX - 1)) ? '0 : ocnt + 1'b1;
    end

    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r9_pred_needs_res: assert property (@(posedge clk) disable iff (!rst_n)
        pred_ready |-> res_valid);

    a_r9_joint_take: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_ready && pred_valid) |-> (res_ready && res_valid));

    a_r10_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (ocnt == CW'(BLK_PIX - 1)));

    a_r10_end_has_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ocnt == CW'(BLK_PIX - 1)) |-> out_last);

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> out_valid);
endmodule

bind pix_recon recon_checks #(.PIX_W(PIX_W), .BLK_PIX(BLK_PIX)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .pred_valid (pred_valid),
    .pred_ready (pred_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
);

// File: tb/pix_recon_bench.sv
`timescale 1ns/1ps
module pix_recon_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0, res_intra = 1'b0, res_packed = 1'b0;
    logic [15:0] res_data = '0;
    logic        pred_valid = 1'b0;
    logic [7:0]  pred_data = '0;
    logic        out_ready = 1'b0;
    logic        res_ready, pred_ready, out_valid, out_last;
    logic [7:0]  out_data;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int stall_pct = 30;
    logic [7:0] exp_q[$];
    bit         last_q[$];
    int         req_q[$];

    always #2.5 clk = ~clk;

    pix_recon u_pix_recon (
        .clk(clk), .rst_n(rst_n),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_intra(res_intra), .res_packed(res_packed),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_data(pred_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    // Reference pixel built from the requirements (R2..R6)
    function automatic logic [7:0] ref_pix(bit intra, bit pk, logic [15:0] r, logic [7:0] p);
        int s;
        if (intra) return r[7:0];
        s = pk ? int'($signed(r[7:0])) : int'($signed(r));
        s = s + int'(p);
        if (s < 0) return 8'd0;
        if (s > 255) return 8'd255;
        return s[7:0];
    endfunction

    // Record one check result
    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Feed one block; kind 0 mid-range, 1 strongly negative, 2 strongly positive
    task automatic run_block(bit intra, bit pk, int kind);
        logic [15:0] r;
        logic [7:0]  p;
        int          rq;
        for (int i = 0; i < 64; i++) begin
            p = 8'($urandom);
            case (kind)
                1: r = pk ? {8'($urandom), 8'h80} : 16'h8000 + 16'($urandom_range(0, 40));
                2: r = pk ? {8'($urandom), 8'h7f} : 16'h7fff - 16'($urandom_range(0, 40));
                default: r = pk ? {8'($urandom), 8'($urandom)}
                                : 16'($urandom_range(0, 600) - 300);
            endcase
            rq = intra ? 2 : (kind == 1 ? 4 : (kind == 2 ? 5 : (pk ? 6 : 3)));
            forever begin
                @(negedge clk);
                res_data   = r;
                pred_data  = p;
                res_valid  = ($urandom_range(0, 99) >= 20);
                pred_valid = ($urandom_range(0, 99) >= 20);
                // R7: after pixel 0 the flags show the opposite mode
                res_intra  = (i == 0) ? intra : !intra;
                res_packed = (i == 0) ? pk : !pk;
                #1;
                if (intra) check(pred_ready == 1'b0, "R8", pred_ready, 0);
                else if (!pred_valid) check(res_ready == 1'b0, "R9", res_ready, 0);
                if (res_valid && res_ready) begin
                    exp_q.push_back(ref_pix(intra, pk, r, p));
                    last_q.push_back(i == 63);
                    req_q.push_back(i > 0 ? 7 : rq);
                    break;
                end
            end
        end
        @(negedge clk);
        res_valid = 1'b0;
        pred_valid = 1'b0;
    endtask

    // Output monitor: randomised ready, compare on each transfer, check holding (R11)
    logic [7:0] held_d;
    bit         held_l;
    bit         stalled = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            out_ready = ($urandom_range(0, 99) >= stall_pct);
            #2;
            if (stalled) begin
                check(out_valid && out_data == held_d && out_last == held_l,
                      "R11", out_data, held_d);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", 1, 0);
                end else begin
                    logic [7:0] e;
                    bit         l;
                    int         q;
                    e = exp_q.pop_front();
                    l = last_q.pop_front();
                    q = req_q.pop_front();
                    // q tags R2 R3 R4 R5 R6 R7
                    if (out_data != e) begin
                        total++; bad++;
                        $display("FAIL R%0d actual=%0d expected=%0d", q, out_data, e);
                    end else total++;
                    check(out_last == l, "R10", out_last, l);
                end
            end
            stalled = out_valid && !out_ready;
            held_d  = out_data;
            held_l  = out_last;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_last == 1'b0, "R1", out_last, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: full throughput probe with no stalls; result due one cycle later
        stall_pct = 0;
        @(negedge clk);
        res_data = 16'h0033; res_intra = 1'b1; res_packed = 1'b0; res_valid = 1'b1;
        #1;
        check(res_ready == 1'b1, "R12", res_ready, 1);
        exp_q.push_back(8'h33); last_q.push_back(1'b0); req_q.push_back(12);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        check(out_valid == 1'b1 && out_data == 8'h33, "R12", out_data, 8'h33);
        // Finish that block as intra (pixels 1..63)
        for (int i = 1; i < 64; i++) begin
            @(negedge clk);
            res_data = 16'(i); res_valid = 1'b1; res_intra = 1'b0;
            #1;
            exp_q.push_back(8'(i)); last_q.push_back(i == 63); req_q.push_back(7);
        end
        @(negedge clk);
        res_valid = 1'b0;
        stall_pct = 30;
        run_block(1'b1, 1'b0, 0);   // R2
        run_block(1'b0, 1'b0, 0);   // R3
        run_block(1'b0, 1'b1, 0);   // R6
        run_block(1'b0, 1'b0, 1);   // R4
        run_block(1'b0, 1'b0, 2);   // R5
        run_block(1'b0, 1'b1, 1);   // R4 and R6
        run_block(1'b1, 1'b1, 0);   // R2 and R8
        run_block(1'b0, 1'b1, 2);   // R5 and R6
        for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R12", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule